// File: doc/BRIEF.md
# Six-Channel Down-Counting Timer Bank

The block is a bank of independent 32-bit down-counters on a simple register bus. Each channel has three registers:

- a control word;
- a reload (interval) value;
- a live count.

A running channel decrements once per prescaled tick, taken from one of two tick inputs. When it reaches zero it flags a pending bit. Depending on its control bits it then reloads, wraps to all-ones, or halts.

Two shared registers sit in front of the channels. One holds a per-channel interrupt enable. The other holds the per-channel pending flags, which software clears by writing ones. One interrupt line is the OR of the pending flags that are enabled.

Each channel is built around a two-state machine with states `CH_IDLE` and `CH_RUN`. Its transitions are:

- **ARM**: `CH_IDLE` to `CH_RUN`, taken on the edge after the start bit reads 1.
- **HALT**: `CH_RUN` to `CH_IDLE`, taken when the start bit reads 0.
- **FIRE_STOP**: `CH_RUN` to `CH_IDLE`, taken on a single-shot expiry.
- **KEEP**: stay in the current state.

The counter and the prescaler advance only in `CH_RUN`. Software can derive elapsed ticks as all-ones minus the live count.

Top module: `timer_bank`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Register map, on word addresses:
  - Interrupt enable at 0x00 and pending status at 0x04. In both, bit n belongs to channel n.
  - For channel n (0..5): control at 0x10+0x10n, interval at 0x14+0x10n, live count at 0x18+0x10n.
  - Any other offset reads zero and ignores writes.
  - Control bits 31:8 read zero.
- R3: Control layout: bit0 start, bit1 reload, bits3:2 tick source, bits6:4 prescale, bit7 single-shot.
  - Tick source 01 selects `tick_osc`, 00 selects `tick_alt`, and 1x selects no tick.
  - A started channel decrements once per prescaled tick of its selected source. A stopped channel holds its count.
  - Counting begins with ticks sampled two clock edges after the edge that writes the start bit.
- R4: The prescale field p divides the selected tick by p+1. A change to p takes effect from the next prescaler wrap.
- R5: A decrement from 1 to 0 sets the channel's pending bit on the same clock edge.
- R6: A decrement taken at a count of 0 behaves in one of two ways:
  - With reload set, it loads the interval value.
  - Without reload, it wraps to 0xFFFFFFFF.
- R7: In single-shot mode, expiry clears the start bit on the same edge. The count then stays at 0, even when reload is also set.
- R8: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. A new expiry in the same cycle as the clear wins.
- R9: `irq` is high exactly when some channel is both pending and enabled.
- R10: A write to the live-count register loads the counter directly, even while the channel is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| tick_osc | input | 1 | Main oscillator tick, one clock wide |
| tick_alt | input | 1 | Alternate tick, one clock wide |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions check three things on every cycle:

- Every expiry leaves its pending bit set on the following cycle.
- Pending bits never drop without a write of one.
- A single-shot expiry always returns the channel to `CH_IDLE` with its start bit clear, and a count of zero.

In addition, an idle channel's count cannot move unless it is written.

Only the directed scenarios can show the numeric behaviour:

- exact decrement counts per tick source;
- the divide ratio and the deferred prescale change;
- the reload value and the all-ones wrap;
- address decoding and the zero read-back of unused offsets.

// File: rtl/timer_bank_pkg.sv
package timer_bank_pkg;
    typedef enum logic [0:0] {CH_IDLE = 1'b0, CH_RUN = 1'b1} ch_state_e;

    localparam int CTRL_W     = 8;
    localparam int B_START    = 0;
    localparam int B_RELOAD   = 1;
    localparam int B_SRC_LO   = 2;
    localparam int B_PRE_LO   = 4;
    localparam int PRE_W      = 3;
    localparam int B_SINGLE   = 7;
    localparam logic [1:0] SRC_ALT = 2'b00;
    localparam logic [1:0] SRC_OSC = 2'b01;
endpackage

// File: rtl/timer_chan.sv
module timer_chan
    import timer_bank_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_osc,
    input  logic              tick_alt,
    input  logic              wr_ctrl,
    input  logic              wr_intv,
    input  logic              wr_cur,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [CNT_W-1:0]  intv_q,
    output logic [CNT_W-1:0]  cur_q,
    output logic              expire
);
    ch_state_e        state_q, state_d;
    logic             running;
    logic             src_tick;
    logic             step;
    logic [PRE_W-1:0] pcnt_q, div_act_q;
    logic [1:0]       src;
    logic [PRE_W-1:0] pre_field;

    assign src       = ctrl_q[B_SRC_LO +: 2];
    assign pre_field = ctrl_q[B_PRE_LO +: PRE_W];

    always_comb begin
        unique case (src)
            SRC_OSC: src_tick = tick_osc;
            SRC_ALT: src_tick = tick_alt;
            default: src_tick = 1'b0;
        endcase
    end

    assign step   = running && src_tick && (pcnt_q == div_act_q);
    assign expire = step && (cur_q == CNT_W'(1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // next state: ARM, HALT, FIRE_STOP, KEEP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (ctrl_q[B_START]) state_d = CH_RUN;
            CH_RUN:  if (!ctrl_q[B_START] || (expire && ctrl_q[B_SINGLE]))
                         state_d = CH_IDLE;
            default: state_d = CH_IDLE;
        endcase
    end

    // outputs of the machine
    always_comb begin
        running = (state_q == CH_RUN);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= wdata[CTRL_W-1:0];
        end else if (expire && ctrl_q[B_SINGLE]) begin
            ctrl_q[B_START] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       intv_q <= '0;
        else if (wr_intv) intv_q <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else if (wr_cur) begin
            cur_q <= wdata;
        end else if (step) begin
            if (cur_q == '0 && ctrl_q[B_RELOAD] && !ctrl_q[B_SINGLE]) cur_q <= intv_q;
            else if (cur_q == '0 && ctrl_q[B_SINGLE])                  cur_q <= cur_q;
            else                                                       cur_q <= cur_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt_q    <= '0;
            div_act_q <= '0;
        end else if (!running) begin
            pcnt_q    <= '0;
            div_act_q <= pre_field;
        end else if (src_tick) begin
            if (pcnt_q == div_act_q) begin
                pcnt_q    <= '0;
                div_act_q <= pre_field;
            end else begin
                pcnt_q <= pcnt_q + 1'b1;
            end
        end
    end

    assert_single_halts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && ctrl_q[B_SINGLE] && !wr_ctrl && !wr_cur)
            |=> (state_q == CH_IDLE && !ctrl_q[B_START] && cur_q == '0));

    assert_idle_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_IDLE && !wr_cur) |=> $stable(cur_q));

    assert_expiry_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !wr_cur) |=> (cur_q == '0));
endmodule

// File: rtl/timer_irq.sv
module timer_irq #(
    parameter int NCH = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic           wr_stat,
    input  logic [NCH-1:0] wdata,
    input  logic [NCH-1:0] expire,
    output logic [NCH-1:0] en_q,
    output logic [NCH-1:0] pend_q,
    output logic           irq
);
    logic [NCH-1:0] clr;

    assign clr = wr_stat ? wdata : '0;

    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (wr_en) en_q <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr) | expire;
    end

    assign irq = |(pend_q & en_q);

    assert_expire_pends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (expire != '0) |=> ((pend_q & $past(expire)) == $past(expire)));

    assert_pend_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & ~clr) != '0)
            |=> ((pend_q & $past(pend_q & ~clr)) == $past(pend_q & ~clr)));
endmodule

// File: rtl/timer_bank.sv
module timer_bank
    import timer_bank_pkg::*;
#(
    parameter int NCH    = 6,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              tick_osc,
    input  logic              tick_alt,
    output logic              irq
);
    localparam int OFS_W  = 4;
    localparam int PAGE_W = ADDR_W - OFS_W;

    logic [PAGE_W-1:0] page;
    logic [OFS_W-1:0]  ofs;
    logic              wr;
    logic [NCH-1:0]    expire, en_q, pend_q;
    logic [CTRL_W-1:0] ctrl_q [NCH];
    logic [CNT_W-1:0]  intv_q [NCH];
    logic [CNT_W-1:0]  cur_q  [NCH];

    assign page = bus_addr[ADDR_W-1:OFS_W];
    assign ofs  = bus_addr[OFS_W-1:0];
    assign wr   = bus_sel && bus_wr;

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        localparam logic [PAGE_W-1:0] PG = PAGE_W'(n + 1);
        logic hit;
        assign hit = wr && (page == PG);
        timer_chan #(.CNT_W(CNT_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_osc(tick_osc),
            .tick_alt(tick_alt),
            .wr_ctrl (hit && ofs == 4'h0),
            .wr_intv (hit && ofs == 4'h4),
            .wr_cur  (hit && ofs == 4'h8),
            .wdata   (bus_wdata),
            .ctrl_q  (ctrl_q[n]),
            .intv_q  (intv_q[n]),
            .cur_q   (cur_q[n]),
            .expire  (expire[n])
        );
    end

    timer_irq #(.NCH(NCH)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr && page == '0 && ofs == 4'h0),
        .wr_stat(wr && page == '0 && ofs == 4'h4),
        .wdata  (bus_wdata[NCH-1:0]),
        .expire (expire),
        .en_q   (en_q),
        .pend_q (pend_q),
        .irq    (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (page == '0) begin
            if (ofs == 4'h0) bus_rdata = CNT_W'(en_q);
            if (ofs == 4'h4) bus_rdata = CNT_W'(pend_q);
        end
        for (int n = 0; n < NCH; n++) begin
            if (page == PAGE_W'(n + 1)) begin
                if (ofs == 4'h0) bus_rdata = CNT_W'(ctrl_q[n]);
                if (ofs == 4'h4) bus_rdata = intv_q[n];
                if (ofs == 4'h8) bus_rdata = cur_q[n];
            end
        end
    end

    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq);
endmodule

// File: tb/tb_timer_bank.sv
module tb_timer_bank;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        tick_osc = 1'b0, tick_alt = 1'b0, irq;
    int          total = 0, bad = 0;
    logic [31:0] rv;

    timer_bank dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_osc(tick_osc), .tick_alt(tick_alt), .irq(irq)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [7:0] a_ctl(int n); return 8'(16 + 16*n); endfunction
    function automatic logic [7:0] a_itv(int n); return 8'(20 + 16*n); endfunction
    function automatic logic [7:0] a_cur(int n); return 8'(24 + 16*n); endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // every task starts and ends just after a falling edge
    task automatic wr32(logic [7:0] a, logic [31:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd32(logic [7:0] a, output logic [31:0] d);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic osc(int n);
        for (int i = 0; i < n; i++) begin
            tick_osc = 1; @(negedge clk); tick_osc = 0; @(negedge clk);
        end
    endtask

    task automatic alt(int n);
        for (int i = 0; i < n; i++) begin
            tick_alt = 1; @(negedge clk); tick_alt = 0; @(negedge clk);
        end
    endtask

    task automatic t_reset;
        rd32(8'h00, rv); check("R1 enable", rv, 0);
        rd32(8'h04, rv); check("R1 status", rv, 0);
        rd32(a_ctl(0), rv); check("R1 ctrl0", rv, 0);
        rd32(a_cur(5), rv); check("R1 cur5", rv, 0);
        check("R1 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_map;
        wr32(a_itv(3), 32'hA5A5_1234);
        rd32(a_itv(3), rv); check("R2 interval3", rv, 32'hA5A5_1234);
        wr32(8'h08, 32'hFFFF_FFFF);
        rd32(8'h08, rv); check("R2 unused 0x08", rv, 0);
        rd32(8'h7C, rv); check("R2 unused 0x7C", rv, 0);
        wr32(a_ctl(5), 32'hFFFF_FF0C);
        rd32(a_ctl(5), rv); check("R2 ctrl reserved bits", rv, 32'h0C);
        wr32(a_ctl(5), 0);
    endtask

    task automatic t_count;
        wr32(a_cur(0), 10);
        wr32(a_ctl(0), 32'h05);
        idle(1);
        osc(3);
        rd32(a_cur(0), rv); check("R3 osc ticks", rv, 7);
        alt(2);
        rd32(a_cur(0), rv); check("R3 other source ignored", rv, 7);
        wr32(a_cur(0), 50);
        rd32(a_cur(0), rv); check("R10 direct load", rv, 50);
        osc(1);
        rd32(a_cur(0), rv); check("R10 count from loaded", rv, 49);
        wr32(a_ctl(0), 32'h04);
        idle(1);
        osc(2);
        rd32(a_cur(0), rv); check("R3 stopped holds", rv, 49);
    endtask

    task automatic t_presc;
        wr32(a_cur(1), 100);
        wr32(a_ctl(1), 32'h25);
        idle(1);
        osc(6);
        rd32(a_cur(1), rv); check("R4 divide by 3", rv, 98);
        wr32(a_ctl(1), 32'h05);
        osc(2);
        rd32(a_cur(1), rv); check("R4 change deferred", rv, 98);
        osc(1);
        rd32(a_cur(1), rv); check("R4 old ratio to wrap", rv, 97);
        osc(1);
        rd32(a_cur(1), rv); check("R4 new ratio", rv, 96);
        wr32(a_ctl(1), 0);
    endtask

    task automatic t_expire;
        wr32(8'h00, 32'h04);
        wr32(a_itv(2), 3);
        wr32(a_cur(2), 2);
        wr32(a_ctl(2), 32'h07);
        idle(1);
        osc(1);
        rd32(8'h04, rv); check("R5 not yet pending", rv, 0);
        osc(1);
        rd32(a_cur(2), rv); check("R5 reached zero", rv, 0);
        rd32(8'h04, rv); check("R5 pending set", rv, 32'h04);
        check("R9 irq high", {31'b0, irq}, 1);
        osc(1);
        rd32(a_cur(2), rv); check("R6 reload interval", rv, 3);
        wr32(a_ctl(2), 0);
        wr32(8'h04, 32'hFFFF_FFFB);
        rd32(8'h04, rv); check("R8 zero write no clear", rv, 32'h04);
        wr32(8'h04, 32'h04);
        rd32(8'h04, rv); check("R8 one clears", rv, 0);
        check("R9 irq low after clear", {31'b0, irq}, 0);
    endtask

    task automatic t_wrap;
        wr32(a_cur(4), 1);
        wr32(a_ctl(4), 32'h05);
        idle(1);
        osc(1);
        rd32(8'h04, rv); check("R5 ch4 pending", rv, 32'h10);
        check("R9 disabled source no irq", {31'b0, irq}, 0);
        osc(1);
        rd32(a_cur(4), rv); check("R6 wrap to ones", rv, 32'hFFFF_FFFF);
        wr32(8'h00, 32'h10);
        idle(1);
        check("R9 enable exposes pending", {31'b0, irq}, 1);
        wr32(a_ctl(4), 0);
        wr32(8'h04, 32'h3F);
        wr32(8'h00, 0);
    endtask

    task automatic t_single;
        wr32(a_itv(3), 9);
        wr32(a_cur(3), 2);
        wr32(a_ctl(3), 32'h87);
        idle(1);
        osc(2);
        rd32(a_ctl(3), rv); check("R7 start cleared", rv, 32'h86);
        osc(3);
        rd32(a_cur(3), rv); check("R7 holds zero", rv, 0);
        rd32(8'h04, rv); check("R7 pending", rv, 32'h08);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog got=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset;
        t_map;
        t_count;
        t_presc;
        t_expire;
        t_wrap;
        t_single;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule